// File: doc/BRIEF.md
# Truncating Float-to-Integer Converter

This block turns an unpacked floating-point operand into a signed two's-complement integer that is `INT_W` bits wide, with `INT_W` either 32 or 64. The operand arrives already split into a sign bit, a two-bit class code, a signed unbiased exponent and a mantissa. The conversion always rounds toward zero.

Two flags come out with the integer. The first reports an invalid conversion: an infinity, a NaN, or a magnitude that the integer cannot hold. In that case the output saturates toward the operand's sign. The second flag reports that nonzero fraction bits were thrown away by the truncation.

The arithmetic is purely combinational. It is captured in one output register, and a valid strobe travels with it, so a result appears exactly one clock after its operand was presented.

The mantissa holds an explicit leading bit. Bit `MANT_W-1` carries weight 2^exp, and each lower bit carries half the weight of the bit above it.

Top module: `f2i_trunc_conv`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first strobed operand, `out_valid`, `out_int`, `out_invalid` and `out_inexact` are all 0.
- R2: `out_valid` equals `in_valid` delayed by one clock. In a cycle where `in_valid` is 0, the three result outputs keep their previous values, whatever is on the other inputs.
- R3: Class code 2'b00 (zero) gives an integer of 0 with both flags clear, for either sign.
- R4: Class code 2'b01 (number) with 0 <= exp < INT_W gives the integer part, truncated toward zero. The integer part is the mantissa shifted right by MANT_W-1-exp. When the sign is 1, the magnitude is negated in two's complement.
- R5: For an in-range number, `out_inexact` is 1 exactly when at least one bit removed by that shift was 1.
- R6: A number with exp < 0 gives 0 and no invalid flag. `out_inexact` is 1 exactly when the mantissa is nonzero.
- R7: A positive number whose truncated magnitude is 2^(INT_W-1) or more gives 2^(INT_W-1)-1, with `out_invalid` set.
- R8: For a negative number, a truncated magnitude of exactly 2^(INT_W-1) is in range and gives the most negative integer with no invalid flag. A larger magnitude gives that same value with `out_invalid` set.
- R9: A number with exp >= INT_W is invalid and saturates toward its sign, whatever the mantissa holds.
- R10: Class code 2'b10 (infinity) and class code 2'b11 (NaN) set `out_invalid`. The output is 2^(INT_W-1)-1 when the sign is 0 and -2^(INT_W-1) when the sign is 1.
- R11: `out_invalid` and `out_inexact` are never 1 together. An invalid result always clears the lost-bits flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking an operand to convert |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_class | input | 2 | 00 zero, 01 number, 10 infinity, 11 NaN |
| in_exp | input | EXP_W | Unbiased exponent, signed |
| in_mant | input | MANT_W | Mantissa; the top bit weighs 2^exp |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_int | output | INT_W | Two's-complement integer result |
| out_invalid | output | 1 | Invalid conversion (special class or out of range) |
| out_inexact | output | 1 | Nonzero bits were discarded by truncation |

## Verification
The bench builds the block with INT_W=32, MANT_W=40 and EXP_W=12. At these values a 64-bit behavioural reference, built on integer division and remainder, can compute every expected integer and flag exactly.

The directed vectors sit at ±2^31, ±(2^31-1), -(2^31+1) and -(2^31+0.5). They also cover exponents of 31, 32 and 40, negative exponents, and fractional values.

A random sweep over exponents from -4 to 40 then reaches every branch of the range check, with mantissas that do not have to be normalized.

// File: rtl/f2i_pkg.sv
package f2i_pkg;
  typedef enum logic [1:0] {
    FC_ZERO = 2'b00,
    FC_NUM  = 2'b01,
    FC_INF  = 2'b10,
    FC_NAN  = 2'b11
  } fclass_e;
endpackage

// File: rtl/f2i_align.sv
// Aligns the mantissa so that its integer part lands in the low INT_W bits,
// and reports whether any fraction bit was lost on the way.
module f2i_align #(
  parameter int INT_W  = 32,
  parameter int MANT_W = 40,
  parameter int EXP_W  = 12
) (
  input  logic signed [EXP_W-1:0]  exp_i,
  input  logic        [MANT_W-1:0] mant_i,
  output logic        [INT_W-1:0]  mag_o,
  output logic                     lost_o,
  output logic                     exp_big_o,
  output logic                     exp_neg_o
);
  localparam int SH_W = $clog2(MANT_W) + 1;

  function automatic logic [INT_W-1:0] int_part(input logic [MANT_W-1:0] m,
                                                input logic [SH_W-1:0]   sh);
    logic [MANT_W-1:0] t;
    t = m >> sh;
    return t[INT_W-1:0];
  endfunction

  function automatic logic frac_nonzero(input logic [MANT_W-1:0] m,
                                        input logic [SH_W-1:0]   sh);
    logic [MANT_W-1:0] keep;
    keep = {MANT_W{1'b1}} << sh;
    return |(m & ~keep);
  endfunction

  logic [SH_W-1:0] shamt;

  always_comb begin
    exp_neg_o = (exp_i < 0);
    exp_big_o = (exp_i >= INT_W);
    shamt     = SH_W'(MANT_W - 1) - SH_W'(exp_i);
    if (exp_neg_o) begin
      mag_o  = '0;
      lost_o = |mant_i;
    end else if (exp_big_o) begin
      mag_o  = '0;
      lost_o = 1'b0;
    end else begin
      mag_o  = int_part(mant_i, shamt);
      lost_o = frac_nonzero(mant_i, shamt);
    end
  end
endmodule

// File: rtl/f2i_range.sv
// Range check: the limit is 2^(INT_W-1) plus the sign bit.
module f2i_range #(
  parameter int INT_W = 32
) (
  input  logic             sign_i,
  input  logic [INT_W-1:0] mag_i,
  output logic             ovf_o
);
  function automatic logic too_big(input logic s, input logic [INT_W-1:0] m);
    logic [INT_W:0] lim;
    lim = ({{INT_W{1'b0}}, 1'b1} << (INT_W - 1)) + {{INT_W{1'b0}}, s};
    return {1'b0, m} >= lim;
  endfunction

  assign ovf_o = too_big(sign_i, mag_i);
endmodule

// File: rtl/f2i_trunc_conv.sv
module f2i_trunc_conv
  import f2i_pkg::*;
#(
  parameter int INT_W  = 32,
  parameter int MANT_W = 40,
  parameter int EXP_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic                     in_sign,
  input  logic [1:0]               in_class,
  input  logic signed [EXP_W-1:0]  in_exp,
  input  logic [MANT_W-1:0]        in_mant,
  output logic                     out_valid,
  output logic [INT_W-1:0]         out_int,
  output logic                     out_invalid,
  output logic                     out_inexact
);
  generate
    if (!(INT_W == 32 || INT_W == 64) || MANT_W < INT_W + 2 || (1 << (EXP_W - 1)) <= INT_W) begin : g_bad_cfg
      $error("f2i_trunc_conv: unsupported parameter set");
    end
  endgenerate

  fclass_e          cls;
  logic [INT_W-1:0] mag_w;
  logic             lost_w, exp_big_w, exp_neg_w, ovf_mag_w;
  logic             is_num_w, is_special_w, invalid_w, inexact_w;
  logic [INT_W-1:0] sat_w, result_w;

  assign cls = fclass_e'(in_class);

  f2i_align #(.INT_W(INT_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) u_align (
    .exp_i     (in_exp),
    .mant_i    (in_mant),
    .mag_o     (mag_w),
    .lost_o    (lost_w),
    .exp_big_o (exp_big_w),
    .exp_neg_o (exp_neg_w)
  );

  f2i_range #(.INT_W(INT_W)) u_range (
    .sign_i (in_sign),
    .mag_i  (mag_w),
    .ovf_o  (ovf_mag_w)
  );

  always_comb begin
    is_num_w     = (cls == FC_NUM);
    is_special_w = (cls == FC_INF) || (cls == FC_NAN);
    invalid_w    = is_special_w || (is_num_w && (exp_big_w || ovf_mag_w));
    inexact_w    = is_num_w && !invalid_w && lost_w;
    sat_w        = {in_sign, {(INT_W-1){~in_sign}}};
    if (invalid_w)      result_w = sat_w;
    else if (!is_num_w) result_w = '0;
    else if (in_sign)   result_w = -mag_w;
    else                result_w = mag_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_int     <= result_w;
        out_invalid <= invalid_w;
        out_inexact <= inexact_w;
      end
    end
  end

  a_r2_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid) || $past(!rst_n));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_int) && $stable(out_invalid) && $stable(out_inexact));
  a_r3_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 2'b00 |=> out_int == '0 && !out_invalid && !out_inexact);
  a_r6_neg_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 2'b01 && exp_neg_w |=> out_int == '0 && !out_invalid);
  a_r9_exp_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class == 2'b01 && exp_big_w |=> out_invalid);
  a_r10_special: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_class[1] |=> out_invalid && out_int[INT_W-1] == $past(in_sign));
  a_r4_sign_match: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && is_num_w && !invalid_w && mag_w != '0 |=> out_int[INT_W-1] == $past(in_sign));
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_invalid && out_inexact));
endmodule

// File: tb/test_f2i_trunc_conv.sv
module test_f2i_trunc_conv;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int MW = 40;
  localparam int EW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sign = 1'b0;
  logic [1:0] in_class = 2'b00;
  logic signed [EW-1:0] in_exp = '0;
  logic [MW-1:0] in_mant = '0;
  logic out_valid, out_invalid, out_inexact;
  logic [N-1:0] out_int;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  f2i_trunc_conv #(.INT_W(N), .MANT_W(MW), .EXP_W(EW)) i_f2i_trunc_conv (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sign(in_sign),
    .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
    .out_valid(out_valid), .out_int(out_int),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  // Behavioural reference: integer division by the weight of the units bit.
  function automatic void ref_conv(input bit s, input bit [1:0] c, input int e,
                                   input longint unsigned m,
                                   output bit [31:0] r, output bit inv, output bit inx);
    longint unsigned div, ip;
    r = 0; inv = 0; inx = 0;
    if (c == 2'b00) return;
    if (c != 2'b01 || e >= N) begin
      inv = 1; r = s ? 32'h8000_0000 : 32'h7fff_ffff; return;
    end
    if (e < 0) begin inx = (m != 0); return; end
    div = 64'd1 << (MW - 1 - e);
    ip  = m / div;
    inx = (m % div) != 0;
    if (ip >= 64'h8000_0000 + longint'(s)) begin
      inv = 1; inx = 0; r = s ? 32'h8000_0000 : 32'h7fff_ffff; return;
    end
    r = s ? 32'(-ip) : 32'(ip);
  endfunction

  task automatic check(input string tag, input bit [31:0] er, input bit ei, input bit ex);
    checks++;
    if (out_valid !== 1'b1 || out_int !== er || out_invalid !== ei || out_inexact !== ex) begin
      errors++;
      $display("FAIL %s: got v=%b int=%h inv=%b inx=%b expected v=1 int=%h inv=%b inx=%b",
               tag, out_valid, out_int, out_invalid, out_inexact, er, ei, ex);
    end
    if (out_invalid && out_inexact) begin
      errors++;
      $display("FAIL R11 (%s): inv=%b inx=%b expected not both set", tag, out_invalid, out_inexact);
    end
  endtask

  task automatic apply(input string tag, input bit s, input bit [1:0] c, input int e,
                       input longint unsigned m);
    bit [31:0] r; bit inv, inx;
    ref_conv(s, c, e, m, r, inv, inx);
    in_sign = s; in_class = c; in_exp = EW'(e); in_mant = MW'(m); in_valid = 1'b1;
    @(negedge clk);
    check(tag, r, inv, inx);
  endtask

  localparam longint unsigned ONE = 64'd1 << 39;

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_int !== 0 || out_invalid !== 0 || out_inexact !== 0) begin
      errors++;
      $display("FAIL R1: got v=%b int=%h inv=%b inx=%b expected all 0",
               out_valid, out_int, out_invalid, out_inexact);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_int !== 0) begin
      errors++;
      $display("FAIL R1 after release: got v=%b int=%h expected 0 0", out_valid, out_int);
    end

    apply("R3 zero pos", 0, 2'b00, 5, 64'h12345);
    apply("R3 zero neg", 1, 2'b00, -2, 0);
    apply("R4 one", 0, 2'b01, 0, ONE);
    apply("R4 R5 5.75", 0, 2'b01, 2, 64'd23 << 35);
    apply("R4 R5 -5.75", 1, 2'b01, 2, 64'd23 << 35);
    apply("R4 max pos", 0, 2'b01, 30, 64'h7fff_ffff << 9);
    apply("R4 -(2^31-1)", 1, 2'b01, 30, 64'h7fff_ffff << 9);
    apply("R6 0.5", 0, 2'b01, -1, ONE);
    apply("R6 -0.5", 1, 2'b01, -1, ONE);
    apply("R6 exp<0 zero mant", 0, 2'b01, -3, 0);
    apply("R7 +2^31", 0, 2'b01, 31, ONE);
    apply("R7 +2^31+0.5", 0, 2'b01, 31, ONE | (64'd1 << 7));
    apply("R8 -2^31", 1, 2'b01, 31, ONE);
    apply("R8 R5 -(2^31+0.5)", 1, 2'b01, 31, ONE | (64'd1 << 7));
    apply("R8 -(2^31+1)", 1, 2'b01, 31, (64'h8000_0001) << 8);
    apply("R9 exp32 pos", 0, 2'b01, 32, ONE);
    apply("R9 exp40 neg", 1, 2'b01, 40, 64'h1);
    apply("R10 +inf", 0, 2'b10, 0, 0);
    apply("R10 -inf", 1, 2'b10, 0, 0);
    apply("R10 nan", 0, 2'b11, 3, 64'hff);

    // R2: an idle cycle with garbage inputs must change nothing.
    in_valid = 1'b0; in_sign = 1'b0; in_class = 2'b01; in_exp = 12'sd3; in_mant = MW'(ONE);
    @(negedge clk);
    checks++;
    if (out_valid !== 0 || out_int !== 32'h7fff_ffff || out_invalid !== 1 || out_inexact !== 0) begin
      errors++;
      $display("FAIL R2 hold: got v=%b int=%h inv=%b inx=%b expected v=0 int=7fffffff inv=1 inx=0",
               out_valid, out_int, out_invalid, out_inexact);
    end

    for (int k = 0; k < 300; k++) begin
      bit [1:0] c;
      int e;
      longint unsigned m;
      c = ($urandom % 8 == 0) ? 2'($urandom) : 2'b01;
      e = int'($urandom % 45) - 4;
      m = {$urandom, $urandom} & ((64'd1 << MW) - 1);
      if (k % 3 == 0) m = m | ONE;
      apply("R4 R5 R7 R8 R9 random", 1'($urandom), c, e, m);
    end
    in_valid = 1'b0;
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule